// File: doc/BRIEF.md
# Parallel Camera Sync Front End

This block sits between a parallel camera sensor port and the capture logic of a chip. It takes the sensor's pixel clock, line sync, frame sync and an 8- or 10-bit data bus, all asynchronous to the system clock. It brings them into the system clock domain and finds the programmed pixel-clock edge. On that edge it emits a single-cycle pixel strobe carrying the captured data.

The edge can be either direction, and the pixel clock and data may each be inverted at the input. In gated mode the line sync qualifies each pixel, with a programmable active level. A frame sync edge of programmable direction marks start of frame. A programmable word count marks end of frame. Both events drive sticky status flags cleared by write-one pulses, a combined interrupt, and a 16-bit frame counter.

The system clock must run at four or more times the pixel clock rate.

Top module: `cam_sync_frontend`

## Requirements
- R1: A pixel is taken on the rising pixel-clock edge when `cfg_latch_rise` is 1 and on the falling edge when it is 0. Each taken pixel gives exactly one `pix_valid` cycle.
- R2: With `cfg_inv_pclk` = 1 the pixel clock is inverted before edge detection, so the capture happens on the opposite pin transition.
- R3: With `cfg_inv_data` = 1 every data bit is inverted before capture.
- R4: With `cfg_gated` = 1 a pixel is taken only while `hsync_in` equals `cfg_hs_high` (1 = active high, 0 = active low).
- R5: With `cfg_gated` = 0 every selected pixel-clock edge gives a pixel, whatever the level of `hsync_in`.
- R6: With `cfg_wide` = 1 `pix_data` carries all 10 bits. With `cfg_wide` = 0 it carries bits 7:0 and bits 9:8 read 0.
- R7: `sof_pulse` is a one-cycle pulse on the rising `vsync_in` edge when `cfg_sof_rise` = 1, and on the falling edge when it is 0. `sof_status` sets only when `cfg_sof_ie` = 1.
- R8: When `cfg_eof_ie` = 1 and `cfg_word_target` is non-zero, `eof_pulse` fires and `eof_status` sets when the pixel count since the last start of frame reaches `cfg_word_target`. With `cfg_eof_ie` = 0 neither happens.
- R9: `frame_count` increments by one on each start of frame. A `frm_cnt_clr` pulse clears it at once.
- R10: `sof_status` and `eof_status` stay set until a one-cycle `sof_clr` or `eof_clr` pulse. `irq` is high while either flag is set.
- R11: After reset, `pix_valid`, both pulses, both status flags, `frame_count` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| pclk_in | input | 1 | Sensor pixel clock, sampled as data |
| hsync_in | input | 1 | Line sync from sensor |
| vsync_in | input | 1 | Frame sync from sensor |
| data_in | input | 10 | Sensor pixel data |
| cfg_latch_rise | input | 1 | 1: capture on rising edge, 0: falling |
| cfg_inv_pclk | input | 1 | Invert pixel clock at input |
| cfg_inv_data | input | 1 | Invert data bus at input |
| cfg_gated | input | 1 | Qualify pixels with line sync |
| cfg_hs_high | input | 1 | Line sync active level, 1 = high |
| cfg_wide | input | 1 | 1: 10-bit pixels, 0: 8-bit |
| cfg_sof_rise | input | 1 | 1: start of frame on rising frame-sync edge, 0: falling |
| cfg_sof_ie | input | 1 | Enable start-of-frame status |
| cfg_eof_ie | input | 1 | Enable end-of-frame detection |
| cfg_word_target | input | 22 | Pixels per frame for end of frame |
| frm_cnt_clr | input | 1 | Clear frame counter |
| sof_clr | input | 1 | Write-one clear of `sof_status` |
| eof_clr | input | 1 | Write-one clear of `eof_status` |
| pix_data | output | 10 | Captured pixel |
| pix_valid | output | 1 | One-cycle pixel strobe |
| sof_pulse | output | 1 | Start-of-frame event |
| eof_pulse | output | 1 | End-of-frame event |
| sof_status | output | 1 | Sticky start-of-frame flag |
| eof_status | output | 1 | Sticky end-of-frame flag |
| frame_count | output | 16 | Frame counter |
| irq | output | 1 | Interrupt, OR of status flags |

## Verification
The properties assume that the pixel clock and frame sync each hold every level for at least two system clocks. Under that assumption the synchronized signals can never show edges in back-to-back cycles, so the strobes are always isolated. They also assume the configuration inputs change only while no sensor edge is in flight. The stimulus holds each pixel-clock level for six or more system clocks. It sets data and line sync four clocks before the capturing edge, and it changes configuration only between edges, with settling time before the counts are taken.

// File: rtl/cam_sync_pkg.sv
package cam_sync_pkg;
  localparam int unsigned PIX_W    = 10;
  localparam int unsigned NARROW_W = 8;
  localparam int unsigned WORD_W   = 22;
  localparam int unsigned FRAME_W  = 16;

  typedef struct packed {
    logic latch_rise;
    logic inv_pclk;
    logic inv_data;
    logic gated;
    logic hs_high;
    logic wide;
  } pix_cfg_t;

  typedef struct packed {
    logic sof_rise;
    logic sof_ie;
    logic eof_ie;
  } frame_cfg_t;
endpackage

// File: rtl/cam_sync_sampler.sv
module cam_sync_sampler #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pclk_in,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              inv_pclk,
  input  logic              inv_data,
  output logic              hsync_s,
  output logic [DATA_W-1:0] data_s,
  output logic              pclk_rise,
  output logic              pclk_fall,
  output logic              vsync_rise,
  output logic              vsync_fall
);
  localparam int unsigned LANE_W   = DATA_W + 3;
  localparam int unsigned PCLK_BIT = LANE_W - 1;
  localparam int unsigned HS_BIT   = LANE_W - 2;
  localparam int unsigned VS_BIT   = LANE_W - 3;

  logic [LANE_W-1:0] lane_in;
  logic [LANE_W-1:0] sync_d [STAGES];
  logic [LANE_W-1:0] sync_q [STAGES];
  logic [LANE_W-1:0] last_q;
  logic              pclk_prev_q, pclk_prev_d;
  logic              vs_prev_q, vs_prev_d;

  // inversion applied ahead of the synchronizer so all lanes share its delay
  assign lane_in = {pclk_in ^ inv_pclk, hsync_in, vsync_in,
                    data_in ^ {DATA_W{inv_data}}};

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign sync_d[i] = lane_in;
    end else begin : g_next
      assign sync_d[i] = sync_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[i] <= '0;
      else        sync_q[i] <= sync_d[i];
    end
  end

  assign last_q = sync_q[STAGES-1];

  always_comb begin
    pclk_prev_d = last_q[PCLK_BIT];
    vs_prev_d   = last_q[VS_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_prev_q <= 1'b0;
      vs_prev_q   <= 1'b0;
    end else begin
      pclk_prev_q <= pclk_prev_d;
      vs_prev_q   <= vs_prev_d;
    end
  end

  assign hsync_s    = last_q[HS_BIT];
  assign data_s     = last_q[DATA_W-1:0];
  assign pclk_rise  =  last_q[PCLK_BIT] & ~pclk_prev_q;
  assign pclk_fall  = ~last_q[PCLK_BIT] &  pclk_prev_q;
  assign vsync_rise =  last_q[VS_BIT]   & ~vs_prev_q;
  assign vsync_fall = ~last_q[VS_BIT]   &  vs_prev_q;
endmodule

// File: rtl/cam_pixel_qualifier.sv
module cam_pixel_qualifier
  import cam_sync_pkg::*;
#(
  parameter int unsigned DATA_W   = 10,
  parameter int unsigned NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pix_cfg_t          cfg,
  input  logic              hsync_s,
  input  logic [DATA_W-1:0] data_s,
  input  logic              pclk_rise,
  input  logic              pclk_fall,
  output logic              pix_valid,
  output logic [DATA_W-1:0] pix_data
);
  logic              edge_hit;
  logic              hs_active;
  logic              take;
  logic [DATA_W-1:0] shaped;
  logic              valid_d, valid_q;
  logic [DATA_W-1:0] data_d, data_q;

  if (DATA_W > NARROW_W) begin : g_mask
    assign shaped = cfg.wide ? data_s
                             : {{(DATA_W-NARROW_W){1'b0}}, data_s[NARROW_W-1:0]};
  end else begin : g_pass
    assign shaped = data_s;
  end

  always_comb begin
    edge_hit  = cfg.latch_rise ? pclk_rise : pclk_fall;
    hs_active = (hsync_s == cfg.hs_high);
    take      = edge_hit & (~cfg.gated | hs_active);
    valid_d   = take;
    data_d    = take ? shaped : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
    end
  end

  assign pix_valid = valid_q;
  assign pix_data  = data_q;
endmodule

// File: rtl/cam_frame_tracker.sv
module cam_frame_tracker
  import cam_sync_pkg::*;
#(
  parameter int unsigned CNT_W = 22,
  parameter int unsigned FRM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  frame_cfg_t       cfg,
  input  logic [CNT_W-1:0] word_target,
  input  logic             vsync_rise,
  input  logic             vsync_fall,
  input  logic             pix_valid,
  input  logic             frm_cnt_clr,
  input  logic             sof_clr,
  input  logic             eof_clr,
  output logic             sof_pulse,
  output logic             eof_pulse,
  output logic             sof_status,
  output logic             eof_status,
  output logic [FRM_W-1:0] frame_count,
  output logic             irq
);
  logic             sof_evt, eof_evt;
  logic [CNT_W-1:0] word_q, word_d, word_inc;
  logic [FRM_W-1:0] frm_q, frm_d;
  logic             sofp_q, sofp_d, eofp_q, eofp_d;
  logic             sofs_q, sofs_d, eofs_q, eofs_d;
  logic             word_en, frm_en;

  always_comb begin
    sof_evt  = cfg.sof_rise ? vsync_rise : vsync_fall;
    word_inc = word_q + 1'b1;
    eof_evt  = pix_valid & ~sof_evt & cfg.eof_ie
             & (word_target != '0) & (word_inc == word_target);

    word_en = sof_evt | pix_valid;
    word_d  = sof_evt ? '0 : word_inc;

    frm_en = frm_cnt_clr | sof_evt;
    frm_d  = frm_cnt_clr ? '0 : frm_q + 1'b1;

    sofp_d = sof_evt;
    eofp_d = eof_evt;
    // a new event wins over a clear arriving in the same cycle
    sofs_d = (sof_evt & cfg.sof_ie) | (sofs_q & ~sof_clr);
    eofs_d = eof_evt | (eofs_q & ~eof_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q <= '0;
    end else if (frm_en) begin
      frm_q <= frm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sofp_q <= 1'b0;
      eofp_q <= 1'b0;
      sofs_q <= 1'b0;
      eofs_q <= 1'b0;
    end else begin
      sofp_q <= sofp_d;
      eofp_q <= eofp_d;
      sofs_q <= sofs_d;
      eofs_q <= eofs_d;
    end
  end

  assign sof_pulse   = sofp_q;
  assign eof_pulse   = eofp_q;
  assign sof_status  = sofs_q;
  assign eof_status  = eofs_q;
  assign frame_count = frm_q;
  assign irq         = sofs_q | eofs_q;
endmodule

// File: rtl/cam_sync_frontend.sv
module cam_sync_frontend
  import cam_sync_pkg::*;
#(
  parameter int unsigned DATA_W   = PIX_W,
  parameter int unsigned NARROW   = NARROW_W,
  parameter int unsigned CNT_W    = WORD_W,
  parameter int unsigned FRM_W    = FRAME_W,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pclk_in,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              cfg_latch_rise,
  input  logic              cfg_inv_pclk,
  input  logic              cfg_inv_data,
  input  logic              cfg_gated,
  input  logic              cfg_hs_high,
  input  logic              cfg_wide,
  input  logic              cfg_sof_rise,
  input  logic              cfg_sof_ie,
  input  logic              cfg_eof_ie,
  input  logic [CNT_W-1:0]  cfg_word_target,
  input  logic              frm_cnt_clr,
  input  logic              sof_clr,
  input  logic              eof_clr,
  output logic [DATA_W-1:0] pix_data,
  output logic              pix_valid,
  output logic              sof_pulse,
  output logic              eof_pulse,
  output logic              sof_status,
  output logic              eof_status,
  output logic [FRM_W-1:0]  frame_count,
  output logic              irq
);
  pix_cfg_t          pcfg;
  frame_cfg_t        fcfg;
  logic              hsync_s;
  logic [DATA_W-1:0] data_s;
  logic              pclk_rise, pclk_fall, vsync_rise, vsync_fall;

  assign pcfg = '{latch_rise: cfg_latch_rise, inv_pclk: cfg_inv_pclk,
                  inv_data: cfg_inv_data, gated: cfg_gated,
                  hs_high: cfg_hs_high, wide: cfg_wide};
  assign fcfg = '{sof_rise: cfg_sof_rise, sof_ie: cfg_sof_ie, eof_ie: cfg_eof_ie};

  cam_sync_sampler #(.DATA_W(DATA_W), .STAGES(SYNC_LEN)) u_sampler (
    .clk(clk), .rst_n(rst_n),
    .pclk_in(pclk_in), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .data_in(data_in), .inv_pclk(pcfg.inv_pclk), .inv_data(pcfg.inv_data),
    .hsync_s(hsync_s), .data_s(data_s),
    .pclk_rise(pclk_rise), .pclk_fall(pclk_fall),
    .vsync_rise(vsync_rise), .vsync_fall(vsync_fall)
  );

  cam_pixel_qualifier #(.DATA_W(DATA_W), .NARROW_W(NARROW)) u_qual (
    .clk(clk), .rst_n(rst_n), .cfg(pcfg),
    .hsync_s(hsync_s), .data_s(data_s),
    .pclk_rise(pclk_rise), .pclk_fall(pclk_fall),
    .pix_valid(pix_valid), .pix_data(pix_data)
  );

  cam_frame_tracker #(.CNT_W(CNT_W), .FRM_W(FRM_W)) u_track (
    .clk(clk), .rst_n(rst_n), .cfg(fcfg), .word_target(cfg_word_target),
    .vsync_rise(vsync_rise), .vsync_fall(vsync_fall), .pix_valid(pix_valid),
    .frm_cnt_clr(frm_cnt_clr), .sof_clr(sof_clr), .eof_clr(eof_clr),
    .sof_pulse(sof_pulse), .eof_pulse(eof_pulse),
    .sof_status(sof_status), .eof_status(eof_status),
    .frame_count(frame_count), .irq(irq)
  );
endmodule

// File: rtl/cam_sync_frontend_chk.sv
module cam_sync_frontend_chk #(
  parameter int unsigned FRM_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_valid,
  input logic             sof_pulse,
  input logic             eof_pulse,
  input logic             sof_status,
  input logic             sof_clr,
  input logic             eof_status,
  input logic             eof_clr,
  input logic             cfg_sof_ie,
  input logic             cfg_eof_ie,
  input logic [FRM_W-1:0] frame_count
);
  p_valid_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid);

  p_sof_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |=> !sof_pulse);

  p_sof_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_pulse && $past(cfg_sof_ie)) |-> sof_status);

  p_eof_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eof_pulse |-> $past(cfg_eof_ie));

  p_eof_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eof_pulse |-> eof_status);

  p_frame_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_count) |->
      (frame_count == $past(frame_count) + 1'b1) || (frame_count == '0));

  p_sof_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_status && !sof_clr) |=> sof_status);

  p_eof_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_status && !eof_clr) |=> eof_status);
endmodule

bind cam_sync_frontend cam_sync_frontend_chk #(.FRM_W(FRM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .sof_pulse(sof_pulse),
  .eof_pulse(eof_pulse), .sof_status(sof_status), .sof_clr(sof_clr),
  .eof_status(eof_status), .eof_clr(eof_clr), .cfg_sof_ie(cfg_sof_ie),
  .cfg_eof_ie(cfg_eof_ie), .frame_count(frame_count)
);

// File: tb/sim_cam_sync_frontend.sv
module sim_cam_sync_frontend;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pclk_in, hsync_in, vsync_in;
  logic [9:0]  data_in;
  logic        cfg_latch_rise, cfg_inv_pclk, cfg_inv_data, cfg_gated, cfg_hs_high, cfg_wide;
  logic        cfg_sof_rise, cfg_sof_ie, cfg_eof_ie;
  logic [21:0] cfg_word_target;
  logic        frm_cnt_clr, sof_clr, eof_clr;
  logic [9:0]  pix_data;
  logic        pix_valid, sof_pulse, eof_pulse, sof_status, eof_status, irq;
  logic [15:0] frame_count;

  int checks = 0;
  int errors = 0;
  int vcnt = 0, sofcnt = 0, eofcnt = 0;
  int last_data = 0;

  always #2 clk = ~clk;

  cam_sync_frontend u0 (
    .clk(clk), .rst_n(rst_n), .pclk_in(pclk_in), .hsync_in(hsync_in),
    .vsync_in(vsync_in), .data_in(data_in),
    .cfg_latch_rise(cfg_latch_rise), .cfg_inv_pclk(cfg_inv_pclk),
    .cfg_inv_data(cfg_inv_data), .cfg_gated(cfg_gated), .cfg_hs_high(cfg_hs_high),
    .cfg_wide(cfg_wide), .cfg_sof_rise(cfg_sof_rise), .cfg_sof_ie(cfg_sof_ie),
    .cfg_eof_ie(cfg_eof_ie), .cfg_word_target(cfg_word_target),
    .frm_cnt_clr(frm_cnt_clr), .sof_clr(sof_clr), .eof_clr(eof_clr),
    .pix_data(pix_data), .pix_valid(pix_valid), .sof_pulse(sof_pulse),
    .eof_pulse(eof_pulse), .sof_status(sof_status), .eof_status(eof_status),
    .frame_count(frame_count), .irq(irq)
  );

  // event monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (pix_valid) begin
      vcnt      <= vcnt + 1;
      last_data <= int'(pix_data);
    end
    if (sof_pulse) sofcnt <= sofcnt + 1;
    if (eof_pulse) eofcnt <= eofcnt + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    wait_clk(1);
    sig = 1'b0;
  endtask

  task automatic pix_tick();
    pclk_in = 1'b1;
    wait_clk(6);
    pclk_in = 1'b0;
    wait_clk(6);
  endtask

  // {latch_rise,inv_pclk,inv_data,gated,hs_high,wide}, hsync, data, exp_count, exp_data
  localparam int NV = 10;
  localparam logic [27:0] VEC [NV] = '{
    {6'b100001, 1'b0, 10'h3A5, 1'b1, 10'h3A5},  // R1 rising capture, R6 wide
    {6'b100000, 1'b0, 10'h3A5, 1'b1, 10'h0A5},  // R6 narrow
    {6'b000001, 1'b0, 10'h155, 1'b0, 10'h000},  // R1 falling select ignores rise
    {6'b010001, 1'b0, 10'h155, 1'b1, 10'h155},  // R2 inverted clock
    {6'b101001, 1'b0, 10'h0F0, 1'b1, 10'h30F},  // R3 inverted data
    {6'b100111, 1'b1, 10'h2C3, 1'b1, 10'h2C3},  // R4 gated, active high, hs on
    {6'b100111, 1'b0, 10'h2C3, 1'b0, 10'h000},  // R4 gated, active high, hs off
    {6'b100101, 1'b0, 10'h11D, 1'b1, 10'h11D},  // R4 gated, active low, hs on
    {6'b100101, 1'b1, 10'h11D, 1'b0, 10'h000},  // R4 gated, active low, hs off
    {6'b100010, 1'b0, 10'h3FF, 1'b1, 10'h0FF}   // R5 hsync ignored, R6 narrow
  };

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {pclk_in, hsync_in, vsync_in} = '0;
    data_in = '0;
    {cfg_latch_rise, cfg_inv_pclk, cfg_inv_data, cfg_gated, cfg_hs_high, cfg_wide} = '0;
    {cfg_sof_rise, cfg_sof_ie, cfg_eof_ie} = '0;
    cfg_word_target = '0;
    {frm_cnt_clr, sof_clr, eof_clr} = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);

    // R11 reset state
    check("R11 pix_valid", int'(pix_valid), 0);
    check("R11 status", int'({sof_status, eof_status, irq}), 0);
    check("R11 frame_count", int'(frame_count), 0);

    for (int k = 0; k < NV; k++) begin
      {cfg_latch_rise, cfg_inv_pclk, cfg_inv_data, cfg_gated, cfg_hs_high, cfg_wide} = VEC[k][27:22];
      pclk_in = 1'b0;
      wait_clk(8);
      vcnt = 0;
      hsync_in = VEC[k][21];
      data_in  = VEC[k][20:11];
      wait_clk(4);
      pclk_in = 1'b1;
      wait_clk(8);
      check($sformatf("R1/R2/R4/R5 vector %0d count", k), vcnt, int'(VEC[k][10]));
      if (VEC[k][10])
        check($sformatf("R3/R6 vector %0d data", k), last_data, int'(VEC[k][9:0]));
      pclk_in = 1'b0;
      wait_clk(8);
    end

    // frame events
    {cfg_latch_rise, cfg_inv_pclk, cfg_inv_data, cfg_gated, cfg_hs_high, cfg_wide} = 6'b100001;
    hsync_in = 1'b0;
    cfg_sof_rise = 1'b1; cfg_sof_ie = 1'b1;
    wait_clk(4);
    sofcnt = 0; eofcnt = 0;
    vsync_in = 1'b1; wait_clk(8);
    check("R7 sof on rise", sofcnt, 1);
    check("R10 sof_status set", int'({sof_status, irq}), 3);
    check("R9 frame_count step", int'(frame_count), 1);
    vsync_in = 1'b0; wait_clk(8);
    check("R7 fall ignored in rise mode", sofcnt, 1);
    wait_clk(20);
    check("R10 sof_status sticky", int'(sof_status), 1);
    pulse(sof_clr); wait_clk(2);
    check("R10 sof_status cleared", int'({sof_status, irq}), 0);

    cfg_sof_rise = 1'b0;
    vsync_in = 1'b1; wait_clk(8);
    check("R7 rise ignored in fall mode", sofcnt, 1);
    vsync_in = 1'b0; wait_clk(8);
    check("R7 sof on fall", sofcnt, 2);
    check("R9 frame_count second", int'(frame_count), 2);
    pulse(sof_clr); wait_clk(2);
    cfg_sof_ie = 1'b0;
    vsync_in = 1'b1; wait_clk(8);
    vsync_in = 1'b0; wait_clk(8);
    check("R7 pulse without enable", sofcnt, 3);
    check("R7 no status when disabled", int'(sof_status), 0);
    pulse(frm_cnt_clr); wait_clk(2);
    check("R9 frame_count cleared", int'(frame_count), 0);

    // end of frame at a count of 3
    cfg_eof_ie = 1'b1; cfg_word_target = 22'd3;
    vsync_in = 1'b1; wait_clk(8);
    vsync_in = 1'b0; wait_clk(8);
    pix_tick(); pix_tick();
    check("R8 no eof before target", eofcnt, 0);
    pix_tick();
    check("R8 eof at target", eofcnt, 1);
    check("R8 eof_status", int'({eof_status, irq}), 3);
    pix_tick();
    check("R8 single eof per frame", eofcnt, 1);
    pulse(eof_clr); wait_clk(2);
    check("R10 eof_status cleared", int'({eof_status, irq}), 0);

    cfg_eof_ie = 1'b0;
    vsync_in = 1'b1; wait_clk(8);
    vsync_in = 1'b0; wait_clk(8);
    pix_tick(); pix_tick(); pix_tick();
    check("R8 eof disabled", eofcnt, 1);
    check("R8 eof_status disabled", int'(eof_status), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule